// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small load/store microcontroller core. Each cycle it takes two operands, a three-bit operation code and the current eight-bit status word. One clock later it presents the result and the updated status word. The supported operations are add, subtract, increment, decrement and bitwise AND.

The status word has a fixed layout. From bit 7 down to bit 0 the bits are: interrupt enable I, transfer bit T, half carry H, sign S, overflow V, negative N, zero Z and carry C. The I and T bits are never changed; they are copied from the incoming word. Subtraction reports a borrow in C and in H, not an inverted carry.

The operand width is the parameter `DATA_W` (default 8). The half carry is taken at the boundary between bit `DATA_W/2-1` and bit `DATA_W/2`, which is bit 3 into bit 4 at the default width. The output registers use a synchronous active-high reset.

Top module: `alu8_status`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o` and `sreg_o` become zero after that edge. Otherwise both outputs show, one cycle later, the values computed from the inputs sampled at the edge.
- R2: Code 0 (add): `res_o` = (a+b) mod 2^DATA_W. C (bit 0) = carry out of the top bit. H (bit 5) = carry from bit DATA_W/2-1 into bit DATA_W/2. For example, 0x38+0x2F gives 0x67 with C=0, H=1, Z=0, and 0x9C+0x64 gives 0x00 with C=1, H=1, Z=1.
- R3: Code 1 (subtract): `res_o` = (a-b) mod 2^DATA_W. C = 1 exactly when b is unsigned-greater than a. H = 1 exactly when the low half of b is unsigned-greater than the low half of a. For example, 0x52-0x73 gives 0xDF with C=1, H=1; 0xA5-0x23 gives 0x82 with C=0, H=0; and 0x9C-0x9C gives 0x00 with C=0, H=0, Z=1.
- R4: Code 2 (increment) gives a+1 and code 3 (decrement) gives a-1, both modulo 2^DATA_W; b is ignored. C and H are copied from `sreg_i`.
- R5: Code 4 (AND) gives a&b. V (bit 3) is cleared, and C and H are copied from `sreg_i`.
- R6: For codes 0 to 4, Z (bit 1) is 1 only when `res_o` is zero, and N (bit 2) equals the top bit of `res_o`.
- R7: For add and increment, V = 1 when both addends (b, or the constant 1) have the same sign and the result sign differs from it. For subtract and decrement, V = 1 when the operand signs differ and the result sign differs from the sign of a.
- R8: For codes 0 to 4, S (bit 4) = N XOR V.
- R9: I (bit 7) and T (bit 6) of `sreg_o` always equal those bits of `sreg_i`.
- R10: Codes 5, 6 and 7 give `res_o` = a and `sreg_o` = `sreg_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| sreg_i | input | 8 | Incoming status word |
| res_o | output | DATA_W | Registered result |
| sreg_o | output | 8 | Registered updated status word |

## Verification
The bench builds one instance with `DATA_W=5`, so that the half-carry boundary falls between bits 1 and 2. At that width every one of the eight operation codes can be applied against every pair of operands. This reaches every carry, borrow, half-carry and overflow combination, and a varied incoming status word shows the pass-through and preserve rules. A second instance at the default width of 8 repeats the worked add and subtract examples. It also sweeps increment and decrement over all 256 operand values, including the signed-overflow edges 0x7F and 0x80 and the wrap at 0xFF.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef logic [2:0] op_t;

  localparam op_t OP_ADD = 3'd0;
  localparam op_t OP_SUB = 3'd1;
  localparam op_t OP_INC = 3'd2;
  localparam op_t OP_DEC = 3'd3;
  localparam op_t OP_AND = 3'd4;

  localparam int SW = 8;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef struct packed {
    logic carry;
    logic half;
    logic ovf;
  } arith_fl_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output alu8_pkg::arith_fl_t fl
);
  localparam int NB = DATA_W / 2;
  localparam int HB = DATA_W - NB;

  logic [DATA_W-1:0] bx;
  logic [NB:0]       lo_s;
  logic [HB:0]       hi_s;

  // Subtraction is a + ~b + 1; the carry-in doubles as the +1.
  assign bx   = sub ? ~b : b;
  assign lo_s = {1'b0, a[NB-1:0]} + {1'b0, bx[NB-1:0]} + {{NB{1'b0}}, sub};
  assign hi_s = {1'b0, a[DATA_W-1:NB]} + {1'b0, bx[DATA_W-1:NB]} + {{HB{1'b0}}, lo_s[NB]};
  assign sum  = {hi_s[HB-1:0], lo_s[NB-1:0]};

  // A borrow is the inverse of the adder carry when subtracting.
  assign fl.carry = hi_s[HB] ^ sub;
  assign fl.half  = lo_s[NB] ^ sub;
  assign fl.ovf   = (a[DATA_W-1] == bx[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_bit
      assign y[i] = a[i] & b[i];
    end
  endgenerate
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_t               op,
  input  logic [DATA_W-1:0] res,
  input  arith_fl_t         fl,
  input  logic [SW-1:0]     sreg_in,
  output logic [SW-1:0]     sreg_out
);
  always_comb begin
    sreg_out = sreg_in;
    case (op)
      OP_ADD, OP_SUB: begin
        sreg_out[FL_C] = fl.carry;
        sreg_out[FL_H] = fl.half;
        sreg_out[FL_V] = fl.ovf;
      end
      OP_INC, OP_DEC: sreg_out[FL_V] = fl.ovf;
      OP_AND:         sreg_out[FL_V] = 1'b0;
      default: ;
    endcase
    if (op <= OP_AND) begin
      sreg_out[FL_Z] = (res == '0);
      sreg_out[FL_N] = res[DATA_W-1];
      sreg_out[FL_S] = sreg_out[FL_N] ^ sreg_out[FL_V];
    end
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [7:0]        sreg_i,
  output logic [DATA_W-1:0] res_o,
  output logic [7:0]        sreg_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] b_eff, sum, and_y, res_n;
  logic              sub;
  arith_fl_t         fl;
  logic [SW-1:0]     sreg_n;

  always_comb begin
    b_eff = b_i;
    sub   = 1'b0;
    case (op_i)
      OP_SUB: sub = 1'b1;
      OP_INC: b_eff = ONE;
      OP_DEC: begin b_eff = ONE; sub = 1'b1; end
      default: ;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(a_i), .b(b_eff), .sub(sub), .sum(sum), .fl(fl)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(a_i), .b(b_i), .y(and_y)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: res_n = sum;
      OP_AND:  res_n = and_y;
      default: res_n = a_i;
    endcase
  end

  alu_flag_merge #(.DATA_W(DATA_W)) u_flags (
    .op(op_i), .res(res_n), .fl(fl), .sreg_in(sreg_i), .sreg_out(sreg_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      sreg_o <= '0;
    end else begin
      res_o  <= res_n;
      sreg_o <= sreg_n;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_o == '0 && sreg_o == '0));

  p_sub_borrow_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SUB) |=> (sreg_o[FL_C] == ($past(b_i) > $past(a_i))));

  p_keep_ch_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INC || op_i == OP_DEC) |=>
      (sreg_o[FL_C] == $past(sreg_i[FL_C]) && sreg_o[FL_H] == $past(sreg_i[FL_H])));

  p_and_clears_v_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND) |=> (!sreg_o[FL_V] && sreg_o[FL_C] == $past(sreg_i[FL_C])));

  p_zero_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i <= OP_AND) |=>
      (sreg_o[FL_Z] == (res_o == '0) && sreg_o[FL_N] == res_o[DATA_W-1]));

  p_sign_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i <= OP_AND) |=> (sreg_o[FL_S] == (sreg_o[FL_N] ^ sreg_o[FL_V])));

  p_it_pass_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sreg_o[FL_I:FL_T] == $past(sreg_i[FL_I:FL_T])));

  p_reserved_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_AND) |=> (sreg_o == $past(sreg_i) && res_o == $past(a_i)));
endmodule

// File: tb/alu8_status_tb_top.sv
module alu8_status_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0] op5 = '0, op8 = '0;
  logic [4:0] a5 = '0, b5 = '0, r5;
  logic [7:0] a8 = '0, b8 = '0, r8;
  logic [7:0] si5 = '0, si8 = '0, so5, so8;

  alu8_status #(.DATA_W(5)) dut_i (
    .clk(clk), .rst(rst), .op_i(op5), .a_i(a5), .b_i(b5), .sreg_i(si5),
    .res_o(r5), .sreg_o(so5));

  alu8_status #(.DATA_W(8)) dut8_i (
    .clk(clk), .rst(rst), .op_i(op8), .a_i(a8), .b_i(b8), .sreg_i(si8),
    .res_o(r8), .sreg_o(so8));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  // Expected {result, status} from the requirements, using plain integers.
  function automatic logic [15:0] model(int w, int op, int a, int b, logic [7:0] si);
    int nb = w / 2;
    int mask = (1 << w) - 1;
    int hm = (1 << nb) - 1;
    int msb = 1 << (w - 1);
    int r = a;
    logic [7:0] so = si;
    logic v = 1'b0;
    case (op)
      0: begin
        r = (a + b) & mask;
        so[0] = ((a + b) >> w) & 1;
        so[5] = (((a & hm) + (b & hm)) >> nb) & 1;
        v = ((a & msb) == (b & msb)) && ((r & msb) != (a & msb));
      end
      1: begin
        r = (a - b) & mask;
        so[0] = b > a;
        so[5] = (b & hm) > (a & hm);
        v = ((a & msb) != (b & msb)) && ((r & msb) != (a & msb));
      end
      2: begin r = (a + 1) & mask; v = (a == msb - 1); end
      3: begin r = (a - 1) & mask; v = (a == msb); end
      4: begin r = a & b; v = 1'b0; end
      default: ;
    endcase
    if (op <= 4) begin
      so[3] = v;
      so[1] = (r == 0);
      so[2] = (r & msb) != 0;
      so[4] = so[2] ^ so[3];
    end
    return {r[7:0], so};
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic compare(int op, int got_r, logic [7:0] got_s, logic [15:0] e);
    string t = op_tag(op);
    chk(t, "result", got_r, int'(e[15:8]));
    chk(t, "C/H", int'({got_s[5], got_s[0]}), int'({e[5], e[0]}));
    if (op <= 4) begin
      chk("R6", "Z/N", int'(got_s[2:1]), int'(e[2:1]));
      chk("R7", "V", int'(got_s[3]), int'(e[3]));
      chk("R8", "S", int'(got_s[4]), int'(e[4]));
    end else begin
      chk("R10", "status", int'(got_s), int'(e[7:0]));
    end
    chk("R9", "I/T", int'(got_s[7:6]), int'(e[7:6]));
  endtask

  task automatic run5(int op, int a, int b, logic [7:0] si);
    op5 = op[2:0]; a5 = a[4:0]; b5 = b[4:0]; si5 = si;
    @(negedge clk);
    compare(op, int'(r5), so5, model(5, op, a, b, si));
  endtask

  task automatic run8(int op, int a, int b, logic [7:0] si);
    op8 = op[2:0]; a8 = a[7:0]; b8 = b[7:0]; si8 = si;
    @(negedge clk);
    compare(op, int'(r8), so8, model(8, op, a, b, si));
  endtask

  initial begin
    op5 = 3'd0; a5 = 5'd7; b5 = 5'd9; si5 = 8'hFF;
    op8 = 3'd0; a8 = 8'h11; b8 = 8'h22; si8 = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset clears both outputs despite nonzero inputs
    chk("R1", "res after reset", int'(r5), 0);
    chk("R1", "status after reset", int'(so5), 0);
    chk("R1", "res8 after reset", int'(r8), 0);
    chk("R1", "status8 after reset", int'(so8), 0);
    rst = 1'b0;

    // Stated 8-bit examples (R2, R3)
    run8(0, 8'h38, 8'h2F, 8'h00);
    chk("R2", "0x38+0x2F", int'({r8, so8[5], so8[1], so8[0]}), int'({8'h67, 3'b100}));
    run8(0, 8'h9C, 8'h64, 8'h00);
    chk("R2", "0x9C+0x64", int'({r8, so8[5], so8[1], so8[0]}), int'({8'h00, 3'b111}));
    run8(1, 8'h52, 8'h73, 8'h00);
    chk("R3", "0x52-0x73", int'({r8, so8[5], so8[1], so8[0]}), int'({8'hDF, 3'b101}));
    run8(1, 8'hA5, 8'h23, 8'hFF);
    chk("R3", "0xA5-0x23", int'({r8, so8[5], so8[1], so8[0]}), int'({8'h82, 3'b000}));
    run8(1, 8'h9C, 8'h9C, 8'h00);
    chk("R3", "0x9C-0x9C", int'({r8, so8[5], so8[1], so8[0]}), int'({8'h00, 3'b010}));

    // R4: full increment/decrement sweep at width 8, status varied
    for (int a = 0; a < 256; a++) begin
      run8(2, a, 255 - a, 8'(a * 37 + 5));
      run8(3, a, a, 8'(a * 91 + 3));
    end
    run8(4, 8'hF0, 8'h3C, 8'h29);   // R5 with C, H set on input
    run8(5, 8'h5A, 8'hFF, 8'hA5);   // R10 reserved code

    // Exhaustive sweep at width 5
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          run5(op, a, b, 8'(a * 7 + b * 13 + op * 29));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule